// File: doc/BRIEF.md
# Serial Register Slave with Indirect Readback

This block is a four-wire serial slave that owns a small bank of control registers. A host frames each transfer by pulling the active-low select low and clocking 32 bits in on the data input, most significant bit first. The bits arrive in this order: a 24-bit payload, a 5-bit register index, and a 3-bit device code. The payload is stored into the indexed register when the select returns high. This happens only if exactly 32 bits arrived and the device code equals the fixed value.

Reads are indirect. The host stores the index it wants into the low bits of register 0, the pointer register. During the next frame the block shifts the selected register out on the serial output, followed by the pointer and the device code. The bits it clocks in during that same frame are still stored as a normal write. A two-step sequence written to register 0 returns every register to its default. The serial pins are sampled by a fast system clock through a synchronizer of configurable depth. The register contents leave the block as plain outputs for the logic they control.

Top module: `spi_regfile_slave`

## Requirements
- R1: The data input is sampled on each rising edge of the serial clock while select is low. A frame is 32 bits, most significant bit first: payload bits 31:8, register index bits 7:3, device code bits 2:0.
- R2: A frame is stored only when select rises after exactly 32 sampled bits and the device code is 110b. Frames with 31 bits, 33 bits or a different code leave every register unchanged.
- R3: Register 1 keeps payload bits 1:0 as the two channel enables (chan_en), default 00.
- R4: Register 2 keeps payload bits 7:0 as the settings byte (cfg), default 05h. In that byte, bits 1:0 are the amplifier bias (01), bits 3:2 are the driver bias (01), and bits 7:4 are 0.
- R5: Register 3 keeps payload bits 8:0 as the gain word, default 0. Higher payload bits are dropped.
- R6: In the frame after a write to register 0, the serial output shifts out a 32-bit word, most significant bit first. The word is the selected register zero-extended to 24 bits, then the 5-bit pointer, then 110b. The output takes each bit on a serial-clock rising edge, so the first rising edge presents bit 31.
- R7: The serial output enable is high only while select is low and low otherwise.
- R8: The bits clocked in during a readback frame are stored exactly like any other write.
- R9: When register 0 holds 20h and a stored frame writes payload 000000h to register 0, all registers return to their defaults. The same write does nothing special when register 0 holds any other value.
- R10: Writes to indices 4 to 31 change nothing. Reading those indices returns a zero payload.
- R11: Register 0 keeps payload bits 5:0, and bits 4:0 of it form the read pointer. Reading index 0 returns those six bits zero-extended.
- R12: After reset the enables are 00, the settings byte is 05h, the gain is 0 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_sen_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial readback data |
| spi_sdo_oe | output | 1 | Output enable for the serial readback pad driver |
| chan_en | output | 2 | Channel enable bits from register 1 |
| cfg | output | 8 | Settings byte from register 2 |
| gain | output | 9 | Gain word from register 3 |

## Verification
The bench builds the block with a three-stage synchronizer, one more than the default. This checks that the frame, commit and readback timing holds when the path from the pins to the edge detectors is longer. The device code keeps its default of 110b, so the bench can reach frames with a wrong code. It can also reach frames one bit short or one bit long, readback of an unassigned index, and both the armed and the unarmed soft-reset paths.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
    localparam int DATA_W   = 24;
    localparam int RADDR_W  = 5;
    localparam int CHIP_W   = 3;
    localparam int FRAME_W  = DATA_W + RADDR_W + CHIP_W;
    localparam int CNT_W    = $clog2(FRAME_W + 2);
    localparam int PTR_W    = 6;
    localparam int EN_W     = 2;
    localparam int CFG_W    = 8;
    localparam int GAIN_W   = 9;
    localparam logic [CFG_W-1:0] CFG_RST  = 8'h05;
    localparam logic [PTR_W-1:0] SRST_ARM = 6'h20;
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stg_d[g] = d_i;
        end else begin : g_next
            assign stg_d[g] = stg_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_rf_shifter.sv
module spi_rf_shifter
    import spi_rf_pkg::*;
#(
    parameter logic [CHIP_W-1:0] CHIP_ID = 3'b110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               sen_n,
    input  logic               sdi,
    input  logic [FRAME_W-1:0] rd_word,
    output logic               wr_valid,
    output logic [RADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic               sdo,
    output logic               sdo_oe
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic               sck_prev;
        logic               sen_prev;
        logic [FRAME_W-1:0] in_sr;
        logic [FRAME_W-1:0] out_sr;
        logic [CNT_W-1:0]   cnt;
        logic               sdo;
        logic               oe;
        logic               wr_valid;
    } sh_state_t;

    sh_state_t st_d, st_q;
    logic sck_rise, sen_fall, sen_rise;

    always_comb begin
        st_d          = st_q;
        st_d.wr_valid = 1'b0;
        st_d.sck_prev = sck;
        st_d.sen_prev = sen_n;
        sck_rise = sck & ~st_q.sck_prev;
        sen_fall = ~sen_n & st_q.sen_prev;
        sen_rise = sen_n & ~st_q.sen_prev;
        if (sen_fall) begin
            st_d.cnt    = '0;
            st_d.out_sr = rd_word;
            st_d.oe     = 1'b1;
        end else if (!sen_n && sck_rise) begin
            st_d.in_sr  = {st_q.in_sr[FRAME_W-2:0], sdi};
            st_d.sdo    = st_q.out_sr[FRAME_W-1];
            st_d.out_sr = {st_q.out_sr[FRAME_W-2:0], 1'b0};
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end
        if (sen_rise) begin
            st_d.oe       = 1'b0;
            st_d.wr_valid = (st_q.cnt == CNT_FULL) &&
                            (st_q.in_sr[CHIP_W-1:0] == CHIP_ID);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.sen_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid = st_q.wr_valid;
    assign wr_addr  = st_q.in_sr[CHIP_W +: RADDR_W];
    assign wr_data  = st_q.in_sr[FRAME_W-1 -: DATA_W];
    assign sdo      = st_q.sdo;
    assign sdo_oe   = st_q.oe;

    // R7
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sen_n && st_q.sen_prev) |-> !sdo_oe);

    // R2
    short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sen_rise && st_q.cnt != CNT_FULL) |=> !wr_valid);
endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
    import spi_rf_pkg::*;
#(
    parameter logic [CHIP_W-1:0] CHIP_ID = 3'b110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [RADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [FRAME_W-1:0] rd_word,
    output logic [EN_W-1:0]    en_o,
    output logic [CFG_W-1:0]   cfg_o,
    output logic [GAIN_W-1:0]  gain_o
);
    typedef struct packed {
        logic [PTR_W-1:0]  r0;
        logic [EN_W-1:0]   en;
        logic [CFG_W-1:0]  cfg;
        logic [GAIN_W-1:0] gain;
    } rf_state_t;

    localparam rf_state_t RF_RST = '{r0: '0, en: '0, cfg: CFG_RST, gain: '0};

    rf_state_t rf_d, rf_q;
    logic [DATA_W-1:0] rd_data;

    always_comb begin
        rf_d = rf_q;
        if (wr_valid) begin
            case (wr_addr)
                5'd0: begin
                    if (rf_q.r0 == SRST_ARM && wr_data == '0) rf_d = RF_RST;
                    else rf_d.r0 = wr_data[PTR_W-1:0];
                end
                5'd1:    rf_d.en   = wr_data[EN_W-1:0];
                5'd2:    rf_d.cfg  = wr_data[CFG_W-1:0];
                5'd3:    rf_d.gain = wr_data[GAIN_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= RF_RST;
        else        rf_q <= rf_d;
    end

    always_comb begin
        rd_data = '0;
        case (rf_q.r0[RADDR_W-1:0])
            5'd0:    rd_data[PTR_W-1:0]  = rf_q.r0;
            5'd1:    rd_data[EN_W-1:0]   = rf_q.en;
            5'd2:    rd_data[CFG_W-1:0]  = rf_q.cfg;
            5'd3:    rd_data[GAIN_W-1:0] = rf_q.gain;
            default: ;
        endcase
    end

    assign rd_word = {rd_data, rf_q.r0[RADDR_W-1:0], CHIP_ID};
    assign en_o    = rf_q.en;
    assign cfg_o   = rf_q.cfg;
    assign gain_o  = rf_q.gain;

    // R2
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(rf_q));

    // R10
    undef_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr > 5'd3) |=> $stable(rf_q));

    // R9
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == 5'd0 && wr_data == '0 && rf_q.r0 == SRST_ARM)
        |=> (en_o == '0 && cfg_o == CFG_RST && gain_o == '0));
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
    import spi_rf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter logic [CHIP_W-1:0] CHIP_ID = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_sen_n,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic [EN_W-1:0]   chan_en,
    output logic [CFG_W-1:0]  cfg,
    output logic [GAIN_W-1:0] gain
);
    logic [2:0]         pins_s;
    logic               wr_valid;
    logic [RADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0]  wr_data;
    logic [FRAME_W-1:0] rd_word;

    spi_rf_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spi_sck, spi_sen_n, spi_sdi}),
        .q_o   (pins_s)
    );

    spi_rf_shifter #(.CHIP_ID(CHIP_ID)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (pins_s[2]),
        .sen_n    (pins_s[1]),
        .sdi      (pins_s[0]),
        .rd_word  (rd_word),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sdo      (spi_sdo),
        .sdo_oe   (spi_sdo_oe)
    );

    spi_rf_regs #(.CHIP_ID(CHIP_ID)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_word  (rd_word),
        .en_o     (chan_en),
        .cfg_o    (cfg),
        .gain_o   (gain)
    );
endmodule

// File: tb/sim_spi_regfile_slave.sv
module sim_spi_regfile_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sen_n = 1'b1, sdi = 1'b0;
    logic sdo, sdo_oe;
    logic [1:0] chan_en;
    logic [7:0] cfg;
    logic [8:0] gain;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    logic [31:0] cap_word;
    event ev_done;

    always #2.5 clk = ~clk;

    spi_regfile_slave #(.SYNC_STAGES(3), .CHIP_ID(3'b110)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_sen_n(sen_n), .spi_sdi(sdi),
        .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .chan_en(chan_en), .cfg(cfg), .gain(gain)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [23:0] d, input logic [4:0] a, input logic [2:0] c);
        return {d, a, c};
    endfunction

    task automatic frame(input logic [31:0] w, input int nbits);
        logic [31:0] rx = '0;
        @(negedge clk) sen_n = 1'b0;
        repeat (8) @(negedge clk);
        chk(sdo_oe === 1'b1, "R7 oe during frame", {31'b0, sdo_oe}, 32'h1);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 32) ? w[31-i] : 1'b0;
            sck = 1'b0;
            repeat (8) @(negedge clk);
            sck = 1'b1;
            repeat (8) @(negedge clk);
            rx = {rx[30:0], sdo};
        end
        sck = 1'b0;
        repeat (8) @(negedge clk);
        sen_n = 1'b1;
        repeat (14) @(negedge clk);
        chk(sdo_oe === 1'b0, "R7 oe idle", {31'b0, sdo_oe}, 32'h0);
        cap_word = rx;
    endtask

    task automatic rd_frame(input logic [31:0] w, input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        frame(w, 32);
        -> ev_done;
        #0;
    endtask

    task automatic chk_regs(input logic [1:0] e, input logic [7:0] c, input logic [8:0] g, input string tag);
        chk(chan_en === e, {tag, " en"}, {30'b0, chan_en}, {30'b0, e});
        chk(cfg === c, {tag, " cfg"}, {24'b0, cfg}, {24'b0, c});
        chk(gain === g, {tag, " gain"}, {23'b0, gain}, {23'b0, g});
    endtask

    initial begin : monitor
        sb_item_t it;
        forever begin
            @(ev_done);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                chk(cap_word === it.exp, it.tag, cap_word, it.exp);
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : driver
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        // R12 reset state, R3 R4 R5 defaults
        chk_regs(2'b00, 8'h05, 9'h000, "R12 reset");
        chk(sdo_oe === 1'b0, "R12 oe reset", {31'b0, sdo_oe}, 32'h0);

        // R1 R5: gain write, upper payload bits dropped
        frame(mk(24'hFFF1A5, 5'd3, 3'b110), 32);
        chk_regs(2'b00, 8'h05, 9'h1A5, "R5 gain write");
        // R3 enables
        frame(mk(24'h000003, 5'd1, 3'b110), 32);
        chk_regs(2'b11, 8'h05, 9'h1A5, "R3 enable write");
        // R4 settings byte
        frame(mk(24'hFFFF8A, 5'd2, 3'b110), 32);
        chk_regs(2'b11, 8'h8A, 9'h1A5, "R4 cfg write");

        // R2 wrong device code, short and long frames
        frame(mk(24'h000011, 5'd3, 3'b101), 32);
        chk_regs(2'b11, 8'h8A, 9'h1A5, "R2 wrong code");
        frame(mk(24'h000022, 5'd3, 3'b110), 31);
        chk_regs(2'b11, 8'h8A, 9'h1A5, "R2 short frame");
        frame(mk(24'h000033, 5'd3, 3'b110), 33);
        chk_regs(2'b11, 8'h8A, 9'h1A5, "R2 long frame");

        // R10 undefined index write
        frame(mk(24'h000055, 5'd7, 3'b110), 32);
        chk_regs(2'b11, 8'h8A, 9'h1A5, "R10 undefined write");

        // R6 readback of gain, enables, settings
        frame(mk(24'h000003, 5'd0, 3'b110), 32);
        rd_frame(mk(24'h000002, 5'd0, 3'b110), mk(24'h0001A5, 5'd3, 3'b110), "R6 read gain");
        rd_frame(mk(24'h000001, 5'd0, 3'b110), mk(24'h00008A, 5'd2, 3'b110), "R6 read cfg");
        rd_frame(mk(24'h000020, 5'd0, 3'b110), mk(24'h000003, 5'd1, 3'b110), "R6 read en");
        // R11 register 0 readback while it holds 20h (armed, not fired)
        rd_frame(mk(24'h000009, 5'd0, 3'b110), mk(24'h000020, 5'd0, 3'b110), "R11 read reg0");
        chk_regs(2'b11, 8'h8A, 9'h1A5, "R9 armed no fire");

        // R10 read undefined index, R8 frame writes gain meanwhile
        rd_frame(mk(24'h0000F0, 5'd3, 3'b110), mk(24'h000000, 5'd9, 3'b110), "R10 read undefined");
        chk_regs(2'b11, 8'h8A, 9'h0F0, "R8 write during read");

        // R9 zero write to reg0 when not armed: no reset
        frame(mk(24'h000000, 5'd0, 3'b110), 32);
        chk_regs(2'b11, 8'h8A, 9'h0F0, "R9 unarmed zero");
        // R9 armed sequence resets everything
        frame(mk(24'h000020, 5'd0, 3'b110), 32);
        frame(mk(24'h000000, 5'd0, 3'b110), 32);
        chk_regs(2'b00, 8'h05, 9'h000, "R9 soft reset");
        rd_frame(mk(24'h000000, 5'd0, 3'b110), mk(24'h000000, 5'd0, 3'b110), "R9 reg0 after reset");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule